// File: doc/BRIEF.md
# Supervisor Register Access Port over SPI

This block is a 16-bit, full-duplex SPI target. It gives a host controller access to four small supervisor registers: a watchdog configuration word that also reports live status inputs, a mode control word, an interrupt enable mask and an interrupt status word. The block samples the SPI pins with the system clock, so that clock must run at least four times faster than the serial clock.

Every frame starts with a four-bit header. The first three bits are the register address and the fourth bit is a read-only flag. The next twelve bits are payload. While the host shifts new payload in, the block shifts out the addressed register's contents as they stood when the header completed. When chip select is released, the payload is committed, but only if exactly sixteen clocks were seen and the flag is clear.

The frame engine has five states:
- `ST_IDLE`: chip select is high.
- `ST_HDR`: the header is being received.
- `ST_DATA`: the payload is being received.
- `ST_FULL`: exactly sixteen bits have been received.
- `ST_OVER`: more than sixteen clocks were seen.

The transitions are:
- `ST_IDLE` to `ST_HDR` when chip select falls.
- `ST_HDR` to `ST_DATA` on the fourth falling clock edge.
- `ST_DATA` to `ST_FULL` on the sixteenth falling clock edge.
- `ST_FULL` to `ST_OVER` on a seventeenth falling clock edge.
- Any state to `ST_IDLE` when chip select rises. A commit happens only when this exit is taken from `ST_FULL`.

Top module: `sbc_spi_regfile`

## Requirements
- R1: Frame layout: bit 15 is sent first, bits 15..13 are the address, bit 12 is the read-only flag and bits 11..0 are the payload. The serial clock idles low, SDI is sampled on its falling edge and SDO is updated on its rising edge.
- R2: The SDO output enable is low while chip select is high and high during a frame.
- R3: SDO returns zeros in bits 15..12. Bits 11..0 are the addressed register's value taken when the header completes.
- R4: A frame with exactly 16 clocks and the read-only flag at 0 writes its payload when chip select rises. With the flag at 1 the register is left unchanged.
- R5: A frame with fewer or more than 16 clocks writes nothing.
- R6: Reset values are: watchdog config 4'b0100, mode word 12'h200 (mode bits 11..10 = 00, bit 9 = 1), interrupt enable 0, interrupt status 0.
- R7: Address 000: bits 11..8 are the writable watchdog config. Bits 7..0 read the live status inputs and ignore writes.
- R8: Address 011: an event input sets its status bit. Writing 1 to a bit clears it, but an event that is present at the same time keeps the bit set.
- R9: The interrupt output (active low) is low while any status bit is set with its enable bit set.
- R10: Addresses 100..111 read zero and ignore writes.
- R11: Address 010 is a plain read/write enable mask. Address 001 is the plain read/write mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sck_i | input | 1 | Serial clock, idles low |
| spi_sdi_i | input | 1 | Serial data in |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdo_oe_o | output | 1 | SDO drive enable; pad floats when low |
| sys_stat_i | input | 8 | Live status shown at address 000 |
| irq_evt_i | input | 12 | Interrupt event inputs, one per status bit |
| wd_cfg_o | output | 4 | Watchdog configuration field |
| mode_o | output | 12 | Mode control word |
| irq_en_o | output | 12 | Interrupt enable mask |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is a clear-write to the interrupt status word that lands in the same cycle as a new event on that bit. The commit moment depends on the synchronizer depth and is not visible at the ports. The stimulus therefore holds the event input high for the whole clearing frame, which guarantees the overlap. A separate read then shows that the bit stayed set. Malformed frames are reached by driving 12 and 17 serial clocks under one chip select, and the following read confirms that the register kept its previous value.

// File: rtl/sbc_spi_pkg.sv
package sbc_spi_pkg;
    localparam int FRAME_W = 16;
    localparam int HDR_W   = 4;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = FRAME_W - HDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [ADDR_W-1:0] A_WDOG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_ISTAT = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_FULL,
        ST_OVER
    } frame_state_e;
endpackage

// File: rtl/sbc_spi_sync.sv
module sbc_spi_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] q_prev_o
);
    logic [WIDTH-1:0] pipe [STAGES+1];

    assign pipe[0] = d_i;

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_prev_o <= RST_VAL;
        else        q_prev_o <= pipe[STAGES];
    end

    assign q_o = pipe[STAGES];
endmodule

// File: rtl/sbc_spi_frame.sv
module sbc_spi_frame
    import sbc_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              sck_i,
    input  logic              sck_prev_i,
    input  logic              sdi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] HDR_DONE  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] FRM_LAST  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FRM_DONE  = CNT_W'(FRAME_W);

    frame_state_e st_q, st_d;
    logic [FRAME_W-1:0] rx_q;
    logic [DATA_W-1:0]  tx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sdo_q;
    logic               sck_rise, sck_fall;

    assign sck_rise = sck_i & ~sck_prev_i;
    assign sck_fall = ~sck_i & sck_prev_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (!csn_i) st_d = ST_HDR;
            ST_HDR:  if (csn_i) st_d = ST_IDLE;
                     else if (sck_fall && cnt_q == HDR_LAST) st_d = ST_DATA;
            ST_DATA: if (csn_i) st_d = ST_IDLE;
                     else if (sck_fall && cnt_q == FRM_LAST) st_d = ST_FULL;
            ST_FULL: if (csn_i) st_d = ST_IDLE;
                     else if (sck_fall) st_d = ST_OVER;
            ST_OVER: if (csn_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= '0;
            tx_q      <= '0;
            cnt_q     <= '0;
            sdo_q     <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (st_q == ST_IDLE) begin
                cnt_q <= '0;
                sdo_q <= 1'b0;
            end else if (csn_i) begin
                wr_en_o   <= (st_q == ST_FULL) && !rx_q[DATA_W];
                wr_addr_o <= rx_q[FRAME_W-1 -: ADDR_W];
                wr_data_o <= rx_q[DATA_W-1:0];
            end else begin
                if (sck_fall) begin
                    rx_q <= {rx_q[FRAME_W-2:0], sdi_i};
                    if (st_q != ST_OVER) cnt_q <= cnt_q + 1'b1;
                end
                if (sck_rise) begin
                    if (st_q == ST_DATA && cnt_q == HDR_DONE) begin
                        sdo_q <= rd_data_i[DATA_W-1];
                        tx_q  <= {rd_data_i[DATA_W-2:0], 1'b0};
                    end else if (st_q == ST_DATA || st_q == ST_FULL) begin
                        sdo_q <= tx_q[DATA_W-1];
                        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
                    end else begin
                        sdo_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign rd_addr_o = rx_q[HDR_W-1:1];
    assign sdo_o     = sdo_q;
    assign sdo_oe_o  = (st_q != ST_IDLE);

    // R2
    sdo_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csn_i) && csn_i) |-> !sdo_oe_o);

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(cnt_q) == FRM_DONE));

    // R4
    commit_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(csn_i));
endmodule

// File: rtl/sbc_spi_regs.sv
module sbc_spi_regs
    import sbc_spi_pkg::*;
#(
    parameter int                STAT_W  = 8,
    parameter int                WCFG_W  = DATA_W - STAT_W,
    parameter logic [WCFG_W-1:0] WD_RST  = 4'b0100,
    parameter logic [DATA_W-1:0] MODE_RST = 12'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [STAT_W-1:0] sys_stat_i,
    input  logic [DATA_W-1:0] irq_evt_i,
    output logic [WCFG_W-1:0] wd_cfg_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] irq_en_o,
    output logic              irq_n_o
);
    logic [WCFG_W-1:0] wd_q;
    logic [DATA_W-1:0] mode_q, ien_q, ist_q;
    logic              clr_sel;

    assign clr_sel = wr_en_i && (wr_addr_i == A_ISTAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q   <= WD_RST;
            mode_q <= MODE_RST;
            ien_q  <= '0;
        end else if (wr_en_i) begin
            unique case (wr_addr_i)
                A_WDOG:  wd_q   <= wr_data_i[DATA_W-1 -: WCFG_W];
                A_MODE:  mode_q <= wr_data_i;
                A_IEN:   ien_q  <= wr_data_i;
                default: ;
            endcase
        end
    end

    genvar b;
    generate
        for (b = 0; b < DATA_W; b++) begin : g_ist
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ist_q[b] <= 1'b0;
                else        ist_q[b] <= irq_evt_i[b] |
                                        (ist_q[b] & ~(clr_sel & wr_data_i[b]));
            end
        end
    endgenerate

    always_comb begin
        unique case (rd_addr_i)
            A_WDOG:  rd_data_o = {wd_q, sys_stat_i};
            A_MODE:  rd_data_o = mode_q;
            A_IEN:   rd_data_o = ien_q;
            A_ISTAT: rd_data_o = ist_q;
            default: rd_data_o = '0;
        endcase
    end

    assign wd_cfg_o = wd_q;
    assign mode_o   = mode_q;
    assign irq_en_o = ien_q;
    assign irq_n_o  = ~|(ist_q & ien_q);

    // R11
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_MODE) |=> (mode_q == $past(wr_data_i)));

    // R8
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel && irq_evt_i == '0) |=> ((ist_q & $past(wr_data_i)) == '0));

    // R9
    irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_evt_i & ien_q)) |=> !irq_n_o);

    // R10
    high_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i[ADDR_W-1]) |=>
            ($stable(mode_q) && $stable(ien_q) && $stable(wd_q)));
endmodule

// File: rtl/sbc_spi_regfile.sv
module sbc_spi_regfile
    import sbc_spi_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter int                 STAT_W      = 8,
    parameter logic [DATA_W-STAT_W-1:0] WD_RST = 4'b0100,
    parameter logic [DATA_W-1:0]  MODE_RST    = 12'h200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_csn_i,
    input  logic                       spi_sck_i,
    input  logic                       spi_sdi_i,
    output logic                       spi_sdo_o,
    output logic                       spi_sdo_oe_o,
    input  logic [STAT_W-1:0]          sys_stat_i,
    input  logic [DATA_W-1:0]          irq_evt_i,
    output logic [DATA_W-STAT_W-1:0]   wd_cfg_o,
    output logic [DATA_W-1:0]          mode_o,
    output logic [DATA_W-1:0]          irq_en_o,
    output logic                       irq_n_o
);
    localparam int WCFG_W = DATA_W - STAT_W;

    logic [2:0] pin_s, pin_p;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;

    sbc_spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     ({spi_csn_i, spi_sck_i, spi_sdi_i}),
        .q_o     (pin_s),
        .q_prev_o(pin_p)
    );

    sbc_spi_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_i     (pin_s[2]),
        .sck_i     (pin_s[1]),
        .sck_prev_i(pin_p[1]),
        .sdi_i     (pin_s[0]),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .sdo_o     (spi_sdo_o),
        .sdo_oe_o  (spi_sdo_oe_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    sbc_spi_regs #(
        .STAT_W  (STAT_W),
        .WCFG_W  (WCFG_W),
        .WD_RST  (WD_RST),
        .MODE_RST(MODE_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .sys_stat_i(sys_stat_i),
        .irq_evt_i (irq_evt_i),
        .wd_cfg_o  (wd_cfg_o),
        .mode_o    (mode_o),
        .irq_en_o  (irq_en_o),
        .irq_n_o   (irq_n_o)
    );
endmodule

// File: tb/tb_sbc_spi_regfile.sv
module tb_sbc_spi_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 6;
    localparam int NVEC       = 13;

    // {frame sent, data expected back}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h3000, 16'h0200},  // R6 R1 read mode (ro)
        {16'h2ABC, 16'h0200},  // R4 write mode, old value returned
        {16'h3000, 16'h0ABC},  // R11 readback
        {16'h3123, 16'h0ABC},  // R4 ro flag set: no write
        {16'h3000, 16'h0ABC},  // R4 unchanged
        {16'h09FF, 16'h04A5},  // R7 write wd cfg, status bits ignored
        {16'h1000, 16'h09A5},  // R7 readback
        {16'h4055, 16'h0000},  // R11 write enable mask
        {16'h5000, 16'h0055},  // R11 readback
        {16'h8FFF, 16'h0000},  // R10 write high addr
        {16'h9000, 16'h0000},  // R10 read high addr
        {16'hFFFF, 16'h0000},  // R10 addr 111
        {16'h3000, 16'h0ABC}   // R10 no side effect on mode
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, irq_n;
    logic [7:0]  sys_stat = 8'hA5;
    logic [11:0] irq_evt = '0;
    logic [3:0]  wd_cfg;
    logic [11:0] mode, irq_en;
    int n_chk = 0, n_bad = 0;
    logic [15:0] rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbc_spi_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .spi_csn_i(csn), .spi_sck_i(sck), .spi_sdi_i(sdi),
        .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe),
        .sys_stat_i(sys_stat), .irq_evt_i(irq_evt),
        .wd_cfg_o(wd_cfg), .mode_o(mode), .irq_en_o(irq_en), .irq_n_o(irq_n)
    );

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] frm, input int nclk, output logic [15:0] cap);
        cap = '0;
        csn = 1'b0;
        waitc(HALF_SCK);
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 16) ? frm[15-i] : 1'b0;
            sck = 1'b1;
            waitc(HALF_SCK);
            if (i < 16) cap[15-i] = sdo;
            if (i == 0) check({15'd0, sdo_oe}, 16'd1, "R2 oe during frame");
            sck = 1'b0;
            waitc(HALF_SCK);
        end
        csn = 1'b1;
        waitc(10);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        waitc(4);
        rst_n = 1'b1;
        waitc(4);
        // R6 reset state
        check({12'd0, wd_cfg}, 16'h0004, "R6 wd cfg reset");
        check({4'd0, mode},    16'h0200, "R6 mode reset");
        check({4'd0, irq_en},  16'h0000, "R6 enable reset");
        check({15'd0, irq_n},  16'h0001, "R6 irq idle");
        check({15'd0, sdo_oe}, 16'h0000, "R2 oe idle");

        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][31:16], 16, rb);
            check(rb, VEC[v][15:0], "R1 R3 vector readback");
        end
        check({4'd0, mode},   16'h0ABC, "R11 mode port");
        check({12'd0, wd_cfg}, 16'h0009, "R7 wd port");
        check({15'd0, sdo_oe}, 16'h0000, "R2 oe after frame");

        // R5 short and long frames
        xfer(16'h2111, 12, rb);
        xfer(16'h3000, 16, rb);
        check(rb, 16'h0ABC, "R5 short frame discarded");
        xfer(16'h2222, 17, rb);
        xfer(16'h3000, 16, rb);
        check(rb, 16'h0ABC, "R5 long frame discarded");

        // R7 live status
        sys_stat = 8'h3C;
        xfer(16'h1000, 16, rb);
        check(rb, 16'h093C, "R7 live status");

        // R8 R9 interrupts (enable mask 0x055)
        irq_evt = 12'h001; waitc(1); irq_evt = '0; waitc(2);
        check({15'd0, irq_n}, 16'h0000, "R9 enabled event");
        xfer(16'h7000, 16, rb);
        check(rb, 16'h0001, "R8 status set");
        xfer(16'h6001, 16, rb);
        xfer(16'h7000, 16, rb);
        check(rb, 16'h0000, "R8 status cleared");
        check({15'd0, irq_n}, 16'h0001, "R9 released");
        irq_evt = 12'h002; waitc(1); irq_evt = '0; waitc(2);
        check({15'd0, irq_n}, 16'h0001, "R9 masked event");
        irq_evt = 12'h002;
        xfer(16'h6002, 16, rb);
        irq_evt = '0; waitc(2);
        xfer(16'h7000, 16, rb);
        check(rb, 16'h0002, "R8 event wins over clear");
        xfer(16'h6002, 16, rb);
        xfer(16'h7000, 16, rb);
        check(rb, 16'h0000, "R8 clear after event");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule